// File: doc/BRIEF.md
# Crypto Descriptor Queue Controller

This block is the front end that feeds a cipher engine from a command ring held in system memory. Software programs four 48-bit pointers: the start and final entry of the ring, the entry to be processed next, and the position after the last queued entry. It then turns the block on through a control/status register. While enabled, the block reads one 64-byte descriptor of eight doublewords over a simple memory read port. It decodes the first doubleword, presents the decoded command to the cipher engine and waits for the engine's done or error response. It then moves the next-entry pointer forward, wrapping at the end of the ring, until that pointer meets the queue end.

Software queues work by writing a descriptor into memory and moving the queue-end pointer forward by one entry (0x40). A read of the drain register holds the register port until the ring is empty, so software can use it as a barrier before it looks at results. A descriptor it cannot run, or an engine error, stops the ring with the faulting entry still current, so software can inspect it and restart.

Top module: `cdq_ctrl`

## Requirements
- R1: After reset the control/status register reads 0 and the ring-start (0x08), ring-final (0x10), next-entry (0x18) and queue-end (0x20) pointers all read 0.
- R2: A write to any of the four pointer offsets keeps only bits 47:0 of the written value; a read of a pointer returns zeros in bits 63:48.
- R3: The control/status register at offset 0x00 reads {60'b0, protocol_error, terminated, busy, enabled} in bits 3:0. A write with bit 0 set turns enabled on and clears terminated and protocol_error; a write with bit 0 clear turns enabled off. Busy is set on the clock edge after enabled is seen with next-entry different from queue-end.
- R4: For each descriptor the block issues eight single-cycle read requests, one outstanding at a time, at entry address + 8*k for k = 0..7 in ascending order.
- R5: While the engine request is high the block presents doubleword 1 bits 47:0 as source, doubleword 5 as key address, doubleword 6 as IV address and doubleword 7 as destination. From doubleword 0 it presents bit 55 as encrypt, bit 54 as start-of-block, bit 53 as end-of-block and bits 23:0 as length minus one.
- R6: The cipher type in doubleword 0 bits 28:24 selects the key size output: 0x13 gives 0 (128-bit key), 0x17 gives 1 (192-bit), 0x1B gives 2 (256-bit).
- R7: After a successful engine done, next-entry advances by 0x40; if that would exceed the ring-final pointer it becomes the ring-start pointer instead.
- R8: Entries are processed back to back until next-entry equals queue-end; busy stays high across consecutive entries, clears once the ring is empty, and enabled stays set.
- R9: A descriptor whose opcode (bits 63:56) is not 0x40, or whose cipher type is not one of the three values of R6, is not sent to the engine. It sets protocol_error and terminated, clears enabled and busy, and leaves next-entry on that descriptor.
- R10: A queue-end write while busy lengthens the work list without re-running the entry in progress; every queued entry reaches the engine exactly once.
- R11: A read of offset 0x30 holds the ready output low while busy is set and completes at once when the block is idle.
- R12: An engine done with error set stops the ring: terminated set, protocol_error unchanged, enabled and busy cleared, next-entry left on that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| reg_rd_rdy | output | 1 | Low while a drain read is being held |
| mem_req | output | 1 | Doubleword read request, one cycle |
| mem_addr | output | 48 | Byte address of the requested doubleword |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| eng_req | output | 1 | Decoded command valid, held until done |
| eng_encrypt | output | 1 | 1 encrypt, 0 decrypt |
| eng_sob | output | 1 | Start-of-block flag |
| eng_eob | output | 1 | End-of-block flag |
| eng_key_sel | output | 2 | Key size: 0 = 128, 1 = 192, 2 = 256 bits |
| eng_len | output | 24 | Byte count minus one |
| eng_src | output | 48 | Source address |
| eng_key_addr | output | 48 | Key address |
| eng_iv_addr | output | 48 | IV address |
| eng_dst | output | 48 | Destination address |
| eng_done | input | 1 | Engine finished the command |
| eng_err | input | 1 | Qualifies eng_done as failed |

## Verification
The hardest case to reach is a queue-end write that lands while one entry is still running, so that the list grows under the sequencer's feet. The stimulus stretches the engine's response latency and writes the queue-end pointer one entry at a time, so that later writes fall inside the busy window. The bench then checks that each queued entry reaches the engine exactly once and in order. Ring wrap-around, the two kinds of bad descriptor and the engine error are directed cases, and each is followed by a restart. Random rounds with random memory and engine latencies then walk the ring many times.

// File: rtl/cdq_pkg.sv
`timescale 1ns/1ps
package cdq_pkg;
  localparam int PA_W        = 48;
  localparam int XW          = 64;
  localparam int ENTRY_DW    = 8;
  localparam int ENTRY_BYTES = ENTRY_DW * (XW / 8);
  localparam int IDX_W       = $clog2(ENTRY_DW);
  localparam int ROFS_W      = 6;
  localparam int LEN_W       = 24;

  localparam logic [ROFS_W-1:0] ROFS_CSR   = 6'h00;
  localparam logic [ROFS_W-1:0] ROFS_FIRST = 6'h08;
  localparam logic [ROFS_W-1:0] ROFS_LAST  = 6'h10;
  localparam logic [ROFS_W-1:0] ROFS_HEAD  = 6'h18;
  localparam logic [ROFS_W-1:0] ROFS_TAIL  = 6'h20;
  localparam logic [ROFS_W-1:0] ROFS_SYNC  = 6'h30;

  localparam logic [7:0] OPC_CIPHER = 8'h40;

  localparam int W_SRC = 1;
  localparam int W_KEY = 5;
  localparam int W_IV  = 6;
  localparam int W_DST = 7;

  typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_EXEC} sq_state_t;

  typedef struct packed {
    logic             op_ok;
    logic             type_ok;
    logic             enc;
    logic             sob;
    logic             eob;
    logic [1:0]       ksel;
    logic [LEN_W-1:0] len;
  } w0_t;

  function automatic logic [PA_W-1:0] keep_low(input logic [XW-1:0] v);
    return v[PA_W-1:0];
  endfunction

  // next entry pointer: one entry forward, back to ring start past the final entry
  function automatic logic [PA_W-1:0] step_head(input logic [PA_W-1:0] h,
                                                input logic [PA_W-1:0] f,
                                                input logic [PA_W-1:0] l);
    logic [PA_W:0] s;
    s = {1'b0, h} + (PA_W+1)'(ENTRY_BYTES);
    return (s > {1'b0, l}) ? f : s[PA_W-1:0];
  endfunction

  function automatic w0_t crack_w0(input logic [XW-1:0] w);
    w0_t        r;
    logic [4:0] t;
    t         = w[28:24];
    r.op_ok   = (w[63:56] == OPC_CIPHER);
    r.type_ok = (t == 5'h13) || (t == 5'h17) || (t == 5'h1B);
    r.enc     = w[55];
    r.sob     = w[54];
    r.eob     = w[53];
    r.ksel    = t[3:2];
    r.len     = w[LEN_W-1:0];
    return r;
  endfunction

  function automatic logic [XW-1:0] csr_pack(input logic en, input logic busy,
                                             input logic term, input logic perr);
    return {{(XW-4){1'b0}}, perr, term, busy, en};
  endfunction
endpackage

// File: rtl/cdq_decode.sv
`timescale 1ns/1ps
module cdq_decode
  import cdq_pkg::*;
(
  input  logic [XW-1:0] w0,
  output w0_t           dec
);
  always_comb dec = crack_w0(w0);
endmodule

// File: rtl/cdq_fetch.sv
`timescale 1ns/1ps
module cdq_fetch
  import cdq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [PA_W-1:0] base,
  output logic            mem_req,
  output logic [PA_W-1:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [XW-1:0]   mem_rdata,
  output logic [XW-1:0]   words [ENTRY_DW],
  output logic            done
);
  logic             active_q;
  logic             wait_q;
  logic [IDX_W-1:0] idx_q;
  logic [PA_W-1:0]  base_q;
  logic             cap;
  logic             last_cap;

  assign mem_req  = active_q && !wait_q;
  assign mem_addr = base_q + PA_W'({idx_q, 3'b000});
  assign cap      = active_q && wait_q && mem_rvalid;
  assign last_cap = cap && (idx_q == IDX_W'(ENTRY_DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wait_q   <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
      done     <= 1'b0;
    end else begin
      done <= last_cap;
      if (go) begin
        active_q <= 1'b1;
        wait_q   <= 1'b0;
        idx_q    <= '0;
        base_q   <= base;
      end else if (mem_req) begin
        wait_q <= 1'b1;
      end else if (cap) begin
        wait_q <= 1'b0;
        idx_q  <= idx_q + 1'b1;
        if (last_cap) active_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < ENTRY_DW; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                words[g] <= '0;
      else if (cap && (idx_q == IDX_W'(g)))      words[g] <= mem_rdata;
    end
  end
endmodule

// File: rtl/cdq_regs.sv
`timescale 1ns/1ps
module cdq_regs
  import cdq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROFS_W-1:0] addr,
  input  logic [XW-1:0]     wdata,
  output logic [XW-1:0]     rdata,
  input  logic              busy,
  input  logic              adv,
  input  logic [PA_W-1:0]   adv_val,
  input  logic              fault,
  input  logic              fail,
  output logic [PA_W-1:0]   first,
  output logic [PA_W-1:0]   last,
  output logic [PA_W-1:0]   head,
  output logic [PA_W-1:0]   tail,
  output logic              en
);
  logic term_q;
  logic perr_q;
  logic csr_wr;

  assign csr_wr = wr_en && (addr == ROFS_CSR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first  <= '0;
      last   <= '0;
      head   <= '0;
      tail   <= '0;
      en     <= 1'b0;
      term_q <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      if (wr_en && addr == ROFS_FIRST) first <= keep_low(wdata);
      if (wr_en && addr == ROFS_LAST)  last  <= keep_low(wdata);
      if (wr_en && addr == ROFS_TAIL)  tail  <= keep_low(wdata);
      if (adv)                                          head <= adv_val;
      else if (wr_en && addr == ROFS_HEAD && !busy)     head <= keep_low(wdata);
      if (fault || fail) begin
        en     <= 1'b0;
        term_q <= 1'b1;
        if (fault) perr_q <= 1'b1;
      end else if (csr_wr) begin
        en <= wdata[0];
        if (wdata[0]) begin
          term_q <= 1'b0;
          perr_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    unique case (addr)
      ROFS_CSR:   rdata = csr_pack(en, busy, term_q, perr_q);
      ROFS_FIRST: rdata = XW'(first);
      ROFS_LAST:  rdata = XW'(last);
      ROFS_HEAD:  rdata = XW'(head);
      ROFS_TAIL:  rdata = XW'(tail);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/cdq_ctrl.sv
`timescale 1ns/1ps
module cdq_ctrl
  import cdq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [5:0]        reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              reg_rd_rdy,
  output logic              mem_req,
  output logic [47:0]       mem_addr,
  input  logic              mem_rvalid,
  input  logic [63:0]       mem_rdata,
  output logic              eng_req,
  output logic              eng_encrypt,
  output logic              eng_sob,
  output logic              eng_eob,
  output logic [1:0]        eng_key_sel,
  output logic [23:0]       eng_len,
  output logic [47:0]       eng_src,
  output logic [47:0]       eng_key_addr,
  output logic [47:0]       eng_iv_addr,
  output logic [47:0]       eng_dst,
  input  logic              eng_done,
  input  logic              eng_err
);
  sq_state_t       state_q;
  logic            busy_q;
  logic [PA_W-1:0] first_q, last_q, head_q, tail_q;
  logic            en_q;
  logic [XW-1:0]   words [ENTRY_DW];
  logic            fetch_done;
  w0_t             dec;

  // named events, also observed by the checker
  logic            st_idle;
  logic            start_evt;
  logic            fault_evt;
  logic            adv_evt;
  logic            fail_evt;
  logic [PA_W-1:0] head_nxt;

  assign st_idle   = (state_q == SQ_IDLE);
  assign start_evt = st_idle && en_q && (head_q != tail_q);
  assign fault_evt = (state_q == SQ_FETCH) && fetch_done && !(dec.op_ok && dec.type_ok);
  assign adv_evt   = (state_q == SQ_EXEC) && eng_done && !eng_err;
  assign fail_evt  = (state_q == SQ_EXEC) && eng_done && eng_err;
  assign head_nxt  = step_head(head_q, first_q, last_q);

  cdq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy_q),
    .adv(adv_evt), .adv_val(head_nxt), .fault(fault_evt), .fail(fail_evt),
    .first(first_q), .last(last_q), .head(head_q), .tail(tail_q), .en(en_q)
  );

  cdq_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .go(start_evt), .base(head_q),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .words(words), .done(fetch_done)
  );

  cdq_decode u_dec (.w0(words[0]), .dec(dec));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      busy_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          busy_q <= start_evt;
          if (start_evt) state_q <= SQ_FETCH;
        end
        SQ_FETCH: if (fetch_done) begin
          if (fault_evt) begin
            state_q <= SQ_IDLE;
            busy_q  <= 1'b0;
          end else begin
            state_q <= SQ_EXEC;
          end
        end
        SQ_EXEC: if (eng_done) begin
          state_q <= SQ_IDLE;
          if (fail_evt) busy_q <= 1'b0;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign reg_rd_rdy   = !(reg_rd_en && (reg_addr == ROFS_SYNC) && busy_q);
  assign eng_req      = (state_q == SQ_EXEC);
  assign eng_encrypt  = dec.enc;
  assign eng_sob      = dec.sob;
  assign eng_eob      = dec.eob;
  assign eng_key_sel  = dec.ksel;
  assign eng_len      = dec.len;
  assign eng_src      = keep_low(words[W_SRC]);
  assign eng_key_addr = keep_low(words[W_KEY]);
  assign eng_iv_addr  = keep_low(words[W_IV]);
  assign eng_dst      = keep_low(words[W_DST]);
endmodule

// File: rtl/cdq_chk.sv
`timescale 1ns/1ps
module cdq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        eng_req,
  input logic        busy,
  input logic        en,
  input logic        fault_evt,
  input logic        adv_evt,
  input logic [47:0] head,
  input logic [47:0] first,
  input logic        reg_wr_en,
  input logic        reg_rd_en,
  input logic [5:0]  reg_addr,
  input logic [63:0] reg_wdata,
  input logic [63:0] reg_rdata,
  input logic        reg_rd_rdy
);
  a_r4_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  a_r8_busy_covers_eng: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> busy);

  a_r9_fault_stops: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (!en && !eng_req && !busy));

  a_r9_fault_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> $stable(head));

  a_r7_adv_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (head == first || head == $past(head) + 48'd64));

  a_r2_ptr_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && (reg_addr == 6'h08 || reg_addr == 6'h10 ||
                   reg_addr == 6'h18 || reg_addr == 6'h20)) |-> (reg_rdata[63:48] == 16'h0));

  a_r11_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> reg_rd_rdy);

  a_r3_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 6'h00 && reg_wdata[0] && !busy) |=> en);
endmodule

bind cdq_ctrl cdq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .eng_req(eng_req),
  .busy(busy_q), .en(en_q), .fault_evt(fault_evt), .adv_evt(adv_evt),
  .head(head_q), .first(first_q), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .reg_rd_rdy(reg_rd_rdy)
);

// File: tb/sim_cdq_ctrl.sv
`timescale 1ns/1ps
module sim_cdq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        reg_rd_rdy;
  logic        mem_req;
  logic [47:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        eng_req, eng_encrypt, eng_sob, eng_eob;
  logic [1:0]  eng_key_sel;
  logic [23:0] eng_len;
  logic [47:0] eng_src, eng_key_addr, eng_iv_addr, eng_dst;
  logic        eng_done = 1'b0, eng_err = 1'b0;

  always #10 clk = ~clk;

  cdq_ctrl u0 (.*);

  int checks = 0, fails = 0;
  logic [63:0] mem [0:511];
  logic [47:0] expq [0:255];
  int ewr = 0, erd = 0;
  logic [47:0] first_v, last_v, etail;
  int eng_lat = 0, mem_lat_max = 0;
  bit inj_err = 0;
  int fk = 0;
  logic [47:0] fprev = '0;
  logic [63:0] rv;
  bit stl;

  task automatic chk(input bit c, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  function automatic int mi(input logic [47:0] a);
    return int'(a[11:3]);
  endfunction

  function automatic logic [47:0] bnext(input logic [47:0] h);
    if (h + 48'd64 > last_v) return first_v;
    return h + 48'd64;
  endfunction

  function automatic logic [1:0] ksel_of(input logic [4:0] t);
    case (t)
      5'h13:   return 2'd0;
      5'h17:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd_en = 1'b1;
    #1 d = reg_rdata;
    reg_rd_en = 1'b0;
  endtask

  task automatic sync_wait(output bit stalled);
    repeat (2) @(negedge clk);
    reg_addr = 6'h30; reg_rd_en = 1'b1;
    #1 stalled = !reg_rd_rdy;
    while (!reg_rd_rdy) begin
      @(negedge clk);
      #1;
    end
    reg_rd_en = 1'b0;
  endtask

  task automatic put_desc(input logic [47:0] a, input logic [7:0] op, input logic [4:0] t);
    int b;
    b = mi(a);
    mem[b] = {op, 1'($urandom), 1'($urandom), 1'($urandom), 24'h0, t, 24'($urandom)};
    for (int i = 1; i < 8; i++)
      mem[b+i] = (i >= 2 && i <= 4) ? 64'h0 : {$urandom, $urandom};
  endtask

  function automatic logic [4:0] rand_type();
    case ($urandom_range(0, 2))
      0:       return 5'h13;
      1:       return 5'h17;
      default: return 5'h1B;
    endcase
  endfunction

  task automatic enq(input int n, input bit each);
    for (int i = 0; i < n; i++) begin
      put_desc(etail, 8'h40, rand_type());
      expq[ewr[7:0]] = etail;
      ewr++;
      etail = bnext(etail);
      if (each) wr(6'h20, {16'hFFFF, etail});
    end
    if (!each) wr(6'h20, {16'h0, etail});
  endtask

  // memory responder: one request at a time, latency at least one cycle
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        logic [47:0] a;
        a = mem_addr;
        // R4: ascending doubleword order inside the entry
        chk(a[5:0] == 6'(fk * 8) && (fk == 0 || a == fprev + 48'd8), "R4 fetch order",
            64'(a), 64'(fprev + 48'd8));
        fprev = a;
        fk = (fk + 1) % 8;
        repeat ($urandom_range(0, mem_lat_max) + 1) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata = mem[mi(a)];
      end
    end
  end

  // engine responder: checks the decoded command against the queued entry
  initial begin
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      eng_err = 1'b0;
      if (eng_req) begin
        chk(erd < ewr, "R10 start count", 64'(erd), 64'(ewr));
        if (erd < ewr) begin
          int b;
          logic [63:0] w0;
          b = mi(expq[erd[7:0]]);
          w0 = mem[b];
          chk(eng_src == mem[b+1][47:0], "R5 source", 64'(eng_src), mem[b+1]);
          chk(eng_key_addr == mem[b+5][47:0] && eng_iv_addr == mem[b+6][47:0] &&
              eng_dst == mem[b+7][47:0], "R5 key/iv/dst", 64'(eng_dst), mem[b+7]);
          chk({eng_encrypt, eng_sob, eng_eob, eng_len} == {w0[55], w0[54], w0[53], w0[23:0]},
              "R5 word0 fields", 64'({eng_encrypt, eng_sob, eng_eob, eng_len}), w0);
          chk(eng_key_sel == ksel_of(w0[28:24]), "R6 key size", 64'(eng_key_sel),
              64'(ksel_of(w0[28:24])));
        end
        erd++;
        repeat (eng_lat) @(negedge clk);
        eng_done = 1'b1;
        eng_err = inj_err;
        inj_err = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [47:0] held;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(6'h00, rv); chk(rv == 64'h0, "R1 csr reset", rv, 64'h0);
    for (int i = 1; i <= 4; i++) begin
      rd(6'(i * 8), rv); chk(rv == 64'h0, "R1 pointer reset", rv, 64'h0);
    end

    // R2 upper bits dropped
    for (int i = 1; i <= 4; i++) begin
      logic [63:0] v;
      v = {$urandom, $urandom} | 64'hFFFF_0000_0000_0000;
      wr(6'(i * 8), v);
      rd(6'(i * 8), rv);
      chk(rv == {16'h0, v[47:0]}, "R2 pointer mask", rv, {16'h0, v[47:0]});
    end

    first_v = 48'h100; last_v = 48'h1C0; etail = 48'h100;
    wr(6'h08, 64'(first_v)); wr(6'h10, 64'(last_v));
    wr(6'h18, 64'(etail));   wr(6'h20, 64'(etail));

    // R3/R8/R11: three entries, start by control write
    enq(3, 1'b0);
    eng_lat = 3;
    wr(6'h00, 64'h1);
    rd(6'h00, rv); chk(rv[3:0] == 4'h3, "R3 enabled and busy", rv, 64'h3);
    sync_wait(stl); chk(stl, "R11 drain read held", 64'(stl), 64'h1);
    chk(erd == ewr, "R8 all entries run", 64'(erd), 64'(ewr));
    rd(6'h18, rv); chk(rv[47:0] == etail, "R7 head advanced", rv, 64'(etail));
    rd(6'h00, rv); chk(rv[3:0] == 4'h1, "R8 busy clear, enabled kept", rv, 64'h1);

    // R7 wrap from final entry back to ring start
    enq(2, 1'b0);
    sync_wait(stl);
    rd(6'h18, rv); chk(rv[47:0] == 48'h140, "R7 wrap", rv, 64'h140);
    chk(erd == ewr, "R8 wrap entries run", 64'(erd), 64'(ewr));

    // R10 queue-end writes while busy
    eng_lat = 25;
    enq(3, 1'b1);
    sync_wait(stl);
    chk(erd == ewr, "R10 each entry once", 64'(erd), 64'(ewr));
    rd(6'h18, rv); chk(rv[47:0] == etail, "R10 head at end", rv, 64'(etail));
    eng_lat = 2;

    // R9 bad opcode
    held = etail;
    put_desc(etail, 8'h41, 5'h13);
    wr(6'h20, 64'(bnext(etail)));
    sync_wait(stl);
    rd(6'h00, rv); chk(rv[3:0] == 4'hC, "R9 opcode fault status", rv, 64'hC);
    rd(6'h18, rv); chk(rv[47:0] == held, "R9 head held", rv, 64'(held));
    chk(erd == ewr, "R9 no engine start", 64'(erd), 64'(ewr));
    put_desc(etail, 8'h40, rand_type());
    expq[ewr[7:0]] = etail; ewr++; etail = bnext(etail);
    wr(6'h00, 64'h1);
    sync_wait(stl);
    rd(6'h00, rv); chk(rv[3:0] == 4'h1, "R3 flags cleared on restart", rv, 64'h1);
    rd(6'h18, rv); chk(rv[47:0] == etail, "R9 recovered", rv, 64'(etail));

    // R9 bad cipher type
    held = etail;
    put_desc(etail, 8'h40, 5'h15);
    wr(6'h20, 64'(bnext(etail)));
    sync_wait(stl);
    rd(6'h00, rv); chk(rv[3:0] == 4'hC, "R9 type fault status", rv, 64'hC);
    rd(6'h18, rv); chk(rv[47:0] == held, "R9 type head held", rv, 64'(held));
    put_desc(etail, 8'h40, rand_type());
    expq[ewr[7:0]] = etail; ewr++; etail = bnext(etail);
    wr(6'h00, 64'h1);
    sync_wait(stl);

    // R12 engine error
    held = etail;
    inj_err = 1'b1;
    enq(1, 1'b0);
    sync_wait(stl);
    rd(6'h00, rv); chk(rv[3:0] == 4'h4, "R12 engine error status", rv, 64'h4);
    rd(6'h18, rv); chk(rv[47:0] == held, "R12 head held", rv, 64'(held));
    expq[ewr[7:0]] = held; ewr++;
    wr(6'h00, 64'h1);
    sync_wait(stl);
    rd(6'h18, rv); chk(rv[47:0] == etail, "R12 recovered", rv, 64'(etail));

    // R11 idle drain read
    sync_wait(stl); chk(!stl, "R11 idle read not held", 64'(stl), 64'h0);

    // R3: disabled ring does not run
    wr(6'h00, 64'h0);
    enq(1, 1'b0);
    repeat (30) @(negedge clk);
    rd(6'h18, rv); chk(rv[47:0] == expq[8'(ewr - 1)], "R3 disabled holds", rv, 64'(expq[8'(ewr - 1)]));
    wr(6'h00, 64'h1);
    sync_wait(stl);

    // random rounds
    mem_lat_max = 3;
    for (int r = 0; r < 30; r++) begin
      eng_lat = $urandom_range(0, 6);
      enq($urandom_range(1, 3), 1'($urandom));
      sync_wait(stl);
      rd(6'h18, rv); chk(rv[47:0] == etail, "R7 random head", rv, 64'(etail));
      chk(erd == ewr, "R8 random drain", 64'(erd), 64'(ewr));
    end

    summary();
    $finish;
  end
endmodule